// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM Core

This block models a synchronous static memory with one dedicated read data output and one dedicated write data input. The two ports share a single address bus. The rising edge of the main clock carries the read address, and its falling edge (the rising edge of the complementary phase) carries the write address. Each port has its own active-low select, so a read and a write can be started in every clock period without the data bus ever turning around.

Every location holds a pair of words, and every access moves both words over two consecutive clock phases (double data rate). Write data arrives on the rising edge after the write address and on the falling edge after that. The pair is then written to the array as a single entry. Read data is launched from output registers 1.5 clock periods after the read address is captured. The low word comes first and the high word follows, with a valid flag high during both beats. A read that targets a write whose second beat is arriving on the same edge gets the new pair forwarded, so the read port always returns the most recent data. The output registers run on the main clock by default. A parameter switches them to a separate output clock. A free-running echo strobe pair marks the output phases for the receiver.

Top module: `qdr_b2_core`

## Requirements
- R1: While reset is held and after its release, `rvalid` is 0 and `rdata` is 0 until the first selected read delivers data.
- R2: The read address and `rd_sel_n` are sampled on the rising edge of `clk`. The write address and `wr_sel_n` are sampled on the falling edge of `clk`. A value on `addr` during the other phase has no effect.
- R3: For a write whose address is taken on falling edge N, `wdata` on the next rising edge is the low word and `wdata` on the falling edge N+1 is the high word. Both words are stored together at that address.
- R4: For a read captured on rising edge k, the low word is on `rdata` from the falling edge after rising edge k+1 until rising edge k+2. The high word is on `rdata` from rising edge k+2 until the next falling edge. `rvalid` is 1 during exactly these two half periods when no other read is pending.
- R5: A rising edge with `rd_sel_n` = 1 starts no read, so no `rvalid` results from it. A falling edge with `wr_sel_n` = 1 starts no write, so the array contents stay unchanged.
- R6: A read and a write can both be issued in every clock period, back to back, to different addresses. Every read returns its correct pair.
- R7: A read captured on rising edge k returns the data of every write whose address was taken on falling edge k-1 or earlier, including a write whose high word is still arriving. A write whose address is taken on falling edge k is not visible to that read.
- R8: `echo_p` equals the output register clock and `echo_n` is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; rising edge is the read phase, falling edge the write phase |
| out_clk | input | 1 | Output register clock, used only when OUT_SEP = 1 |
| rst_n | input | 1 | Asynchronous active-low reset of control and output state |
| addr | input | AW | Shared address, read on rise and write on fall |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| wdata | input | W | Write data, two beats per write |
| rdata | output | W | Read data, two beats per read |
| rvalid | output | 1 | High while a read beat is on rdata |
| echo_p | output | 1 | Echo strobe in phase with the output clock |
| echo_n | output | 1 | Complement of echo_p |

## Verification
The assertions check several things on every clock edge. A select samples its address on its own phase, and a deselected phase starts nothing. A pending read always reaches the low-beat valid two falling edges later, and a low-beat valid is always followed by a high-beat valid. When a read meets a write to the same address that is still in flight, the forwarded pair equals the incoming beats. Only the bench scenarios can show the end-to-end data: what was stored against what is returned, the exact half-period placement of each beat at the port, the ordering rule against writes captured on the same or earlier edges, and the absence of any effect from a deselected write.

// File: rtl/qdr_b2_core.sv
module qdr_b2_core #(
  parameter int DEPTH   = 256,
  parameter int W       = 36,
  parameter bit OUT_SEP = 1'b0,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          out_clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rvalid,
  output logic          echo_p,
  output logic          echo_n
);

  logic [2*W-1:0] mem [DEPTH];

  logic          r_act, w_act1, w_act2, rd_buf_v, lo_v, hi_v;
  logic [AW-1:0] r_addr, w_addr1, w_addr2;
  logic [W-1:0]  w_beat0, lo_q, hi_q, hi_hold;
  logic [2*W-1:0] rd_buf, rd_word, w_pair;
  logic          fwd_hit, ock;

  assign ock     = OUT_SEP ? out_clk : clk;
  assign w_pair  = {wdata, w_beat0};
  assign fwd_hit = w_act2 && (w_addr2 == r_addr);
  assign rd_word = fwd_hit ? w_pair : mem[r_addr];

  // rising edge: read capture, write low beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act  <= 1'b0;
      w_act2 <= 1'b0;
    end else begin
      r_act  <= !rd_sel_n;
      w_act2 <= w_act1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rd_sel_n) r_addr <= addr;
    if (w_act1) begin
      w_addr2 <= w_addr1;
      w_beat0 <= wdata;
    end
  end

  // falling edge: write capture, commit, array read
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_act1   <= 1'b0;
      rd_buf_v <= 1'b0;
      rd_buf   <= '0;
    end else begin
      w_act1   <= !wr_sel_n;
      rd_buf_v <= r_act;
      if (r_act) rd_buf <= rd_word;
    end
  end

  always_ff @(negedge clk) begin
    if (!wr_sel_n) w_addr1 <= addr;
    if (w_act2) mem[w_addr2] <= w_pair;
  end

  // output registers
  always_ff @(negedge ock or negedge rst_n) begin
    if (!rst_n) begin
      lo_v    <= 1'b0;
      lo_q    <= '0;
      hi_hold <= '0;
    end else begin
      lo_v    <= rd_buf_v;
      lo_q    <= rd_buf[W-1:0];
      hi_hold <= rd_buf[2*W-1:W];
    end
  end

  always_ff @(posedge ock or negedge rst_n) begin
    if (!rst_n) begin
      hi_v <= 1'b0;
      hi_q <= '0;
    end else begin
      hi_v <= lo_v;
      hi_q <= hi_hold;
    end
  end

  assign rdata  = ock ? hi_q : lo_q;
  assign rvalid = ock ? hi_v : lo_v;
  assign echo_p = ock;
  assign echo_n = !ock;

endmodule

// File: rtl/qdr_b2_core_chk.sv
module qdr_b2_core_chk #(
  parameter int AW = 8,
  parameter int W  = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic          wr_sel_n,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          r_act,
  input logic [AW-1:0] r_addr,
  input logic          w_act1,
  input logic          w_act2,
  input logic [AW-1:0] w_addr2,
  input logic [W-1:0]  w_beat0,
  input logic          rd_buf_v,
  input logic [2*W-1:0] rd_buf,
  input logic          lo_v,
  input logic          hi_v
);

  // R2
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_n |=> (r_act && r_addr == $past(addr)));

  // R5
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_n |=> !r_act);

  // R5
  wr_ignore_chk: assert property (@(negedge clk) disable iff (!rst_n)
    wr_sel_n |=> !w_act1);

  // R7
  fwd_data_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (r_act && w_act2 && w_addr2 == r_addr) |=> (rd_buf_v && rd_buf == $past({wdata, w_beat0})));

  // R4
  lo_latency_chk: assert property (@(negedge clk) disable iff (!rst_n)
    r_act |-> ##2 lo_v);

  // R4
  beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_v |=> hi_v);

endmodule

bind qdr_b2_core qdr_b2_core_chk #(.AW(AW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .addr(addr), .wdata(wdata), .r_act(r_act), .r_addr(r_addr),
  .w_act1(w_act1), .w_act2(w_act2), .w_addr2(w_addr2), .w_beat0(w_beat0),
  .rd_buf_v(rd_buf_v), .rd_buf(rd_buf), .lo_v(lo_v), .hi_v(hi_v)
);

// File: tb/tb_qdr_b2_core.sv
module tb_qdr_b2_core;
  localparam int DEPTH = 256;
  localparam int W     = 36;
  localparam int AW    = $clog2(DEPTH);
  localparam int NE    = 2048;

  logic clk = 1'b0, rst_n = 1'b0, rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic rvalid, echo_p, echo_n;

  qdr_b2_core #(.DEPTH(DEPTH), .W(W)) dut (
    .clk(clk), .out_clk(clk), .rst_n(rst_n), .addr(addr),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .echo_p(echo_p), .echo_n(echo_n));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, pcnt = 0;
  bit mon_en = 0, done = 0;
  string cur_req = "R1";
  logic [2*W-1:0] model [DEPTH];
  bit       exp_v  [NE];
  logic [W-1:0] exp_lo [NE];
  logic [W-1:0] exp_hi [NE];
  logic [W-1:0] pb0 = '0, pb1 = '0;

  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // beat monitors (R4 placement, data per current scenario tag)
  always @(negedge clk) begin
    #3;
    if (mon_en && pcnt < NE) begin
      chk("R4", W'(rvalid), W'(exp_v[pcnt]), "low-beat rvalid");
      if (exp_v[pcnt]) chk(cur_req, rdata, exp_lo[pcnt], "low beat");
    end
  end
  always @(posedge clk) begin
    #3;
    if (mon_en && pcnt >= 1 && pcnt <= NE) begin
      chk("R4", W'(rvalid), W'(exp_v[pcnt-1]), "high-beat rvalid");
      if (exp_v[pcnt-1]) chk(cur_req, rdata, exp_hi[pcnt-1], "high beat");
    end
  end

  // one clock period: read on the rise, write on the fall; called in the low phase
  task automatic cyc(input bit re, input int ra, input bit we, input int wa,
                     input logic [W-1:0] d0, input logic [W-1:0] d1);
    int k;
    addr = AW'(ra); rd_sel_n = !re; wdata = pb0;
    @(posedge clk); #2;
    k = pcnt;
    if (re && k + 1 < NE) begin
      exp_v[k+1]  = 1'b1;
      exp_lo[k+1] = model[ra][W-1:0];
      exp_hi[k+1] = model[ra][2*W-1:W];
    end
    rd_sel_n = 1'b1;
    addr = AW'(wa); wr_sel_n = !we; wdata = pb1;
    if (we) model[wa] = {d1, d0};
    @(negedge clk); #2;
    wr_sel_n = 1'b1;
    addr = ~AW'(wa);
    pb0 = d0; pb1 = d1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, '0);
  endtask

  function automatic logic [W-1:0] pat(input int a, input int s);
    return {4'(s), 32'(a * 32'h01010101 + s * 32'h00f00f01)};
  endfunction

  task automatic t_reset();
    cur_req = "R1";
    chk("R1", W'(rvalid), '0, "rvalid in reset");
    chk("R1", rdata, '0, "rdata in reset");
    @(negedge clk); #2; rst_n = 1'b1;
    mon_en = 1;
    idle(3);
    chk("R1", rdata, '0, "rdata after reset");
  endtask

  task automatic t_fill_and_read();
    cur_req = "R3";
    for (int a = 0; a < 16; a++) cyc(0, 0, 1, a, pat(a, 1), pat(a, 2));
    idle(2);
    for (int a = 0; a < 16; a++) cyc(1, a, 0, 0, '0, '0);
    idle(3);
    for (int a = 15; a >= 0; a -= 3) begin cyc(1, a, 0, 0, '0, '0); idle(1); end
    idle(3);
  endtask

  task automatic t_deselect();
    cur_req = "R5";
    cyc(0, 5, 0, 5, pat(99, 7), pat(99, 8));
    idle(2);
    cyc(1, 5, 0, 0, '0, '0);
    idle(3);
    chk("R5", W'(rvalid), '0, "no valid after idle");
  endtask

  task automatic t_concurrent();
    cur_req = "R6";
    for (int i = 0; i < 24; i++)
      cyc(1, i % 16, 1, 32 + i, pat(32 + i, 3), pat(32 + i, 4));
    idle(2);
    cur_req = "R2";
    for (int i = 0; i < 24; i++) cyc(1, 32 + i, 1, 100 + i, pat(i, 5), pat(i, 6));
    idle(3);
  endtask

  task automatic t_coherent();
    cur_req = "R7";
    cyc(1, 200, 1, 200, pat(200, 9), pat(200, 10));
    cyc(1, 200, 0, 0, '0, '0);
    cyc(1, 200, 1, 200, pat(200, 11), pat(200, 12));
    cyc(1, 200, 1, 200, pat(200, 13), pat(200, 14));
    cyc(1, 200, 0, 0, '0, '0);
    cyc(1, 200, 0, 0, '0, '0);
    idle(3);
  endtask

  task automatic t_echo();
    @(negedge clk); #3;
    chk("R8", W'(echo_p), '0, "echo_p low phase");
    chk("R8", W'(echo_n), W'(1), "echo_n low phase");
    @(posedge clk); #3;
    chk("R8", W'(echo_p), W'(1), "echo_p high phase");
    chk("R8", W'(echo_n), '0, "echo_n high phase");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NE; i++) exp_v[i] = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #1;
    t_reset();
    // preload touched locations so no read sees an unwritten entry
    cur_req = "R3";
    for (int a = 0; a < 60; a++) cyc(0, 0, 1, a, pat(a, 0), pat(a, 15));
    cyc(0, 0, 1, 200, pat(7, 7), pat(8, 8));
    for (int a = 100; a < 124; a++) cyc(0, 0, 1, a, pat(a, 0), pat(a, 14));
    idle(2);
    t_fill_and_read();
    t_deselect();
    t_concurrent();
    t_coherent();
    t_echo();
    mon_en = 0;
    finish_run();
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule